// File: doc/BRIEF.md
# Prescaled Down-Counting PWM Channel

This block is a single PWM timer channel. A programmable clock divider produces count ticks. Each tick decrements a down counter that is reloaded from a period value. The counter is compared against a duty value to form the PWM waveform.

The period and duty values are written into staging registers. They reach the running channel only when a new PWM cycle starts, so a write never disturbs the cycle already in progress. The channel runs either once (one-shot) or continuously (auto-reload). Whenever the counter lands on zero it raises a sticky interrupt flag, and software clears that flag with a one-cycle strobe.

The output polarity can be inverted, the output can be gated off, and the live counter value is always visible. Bus decoding, clock-source selection and pin multiplexing are handled outside the block.

Top module: `pwm_down_channel`

## Requirements
- R1: While `run_en` is 1, a divider counts system clocks. It fires a count tick on the clock where its count is at least `prescale`, then returns to 0, so the counter moves once every `prescale`+1 clocks. While `run_en` is 0 the divider is held at 0.
- R2: `count_val` is the counter register itself. While `run_en` is 0 the counter keeps its value.
- R3: The first tick after `run_en` becomes 1 starts a PWM cycle. On that tick the counter loads the staged period and the active duty loads the staged duty.
- R4: A write through `period_wr` or `duty_wr` lands only in the staging registers. It reaches the counter and the active duty at the next cycle start, never in the middle of a cycle.
- R5: A tick with the counter at 0 starts a new cycle when `mode_reload` is 1. When `mode_reload` is 0 the counter stays at 0 until `run_en` is taken low and raised again. A tick at a nonzero value decrements the counter by one.
- R6: `pwm_out` is registered and reflects the state one clock earlier. The raw level is 1 when `run_en` is 1 and the counter is greater than the active duty, otherwise 0. That level is XORed with `out_inv`, and the result is forced to 0 when `out_en` is 0. A stopped channel therefore drives `out_inv` when enabled.
- R7: A 0-to-1 change of `mode_reload` clears the staged period, the staged duty and the active duty. The clear wins over a write in the same clock, and it leaves the counter unchanged.
- R8: A tick that takes the counter from 1 to 0 sets the flag. A 1 on `flag_clr` clears the flag, but a set in the same clock wins. `irq` is the registered AND of the next flag value and `irq_en`.
- R9: After a synchronous reset, `count_val`, `pwm_out` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prescale | input | PSC_W | Divider value; the counter ticks every value+1 clocks |
| run_en | input | 1 | 1 runs the channel, 0 stops it |
| mode_reload | input | 1 | 1 auto-reload, 0 one-shot |
| out_inv | input | 1 | Inverts output polarity |
| out_en | input | 1 | Gates the output; 0 drives 0 |
| irq_en | input | 1 | Interrupt enable |
| period_wr | input | 1 | Write strobe for the staged period |
| period_data | input | CNT_W | Period value to stage |
| duty_wr | input | 1 | Write strobe for the staged duty |
| duty_data | input | CNT_W | Duty value to stage |
| flag_clr | input | 1 | Write-one strobe clearing the flag |
| pwm_out | output | 1 | PWM waveform |
| count_val | output | CNT_W | Live counter value |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default widths: an 8-bit divider and a 16-bit counter. It drives the divider only with values 0 to 3 and keeps periods below about 20. At those values many reloads, zero crossings and flag collisions fit into a few thousand clocks. The random runs toggle mode, enable and polarity often enough to hit mode-rise clears that land on writes and on cycle starts, as well as one-shot halts and restarts.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  typedef struct packed {
    logic run;
    logic reload;
    logic inv;
    logic oe;
  } pwm_ctrl_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic [PSC_W-1:0] div_q;

  assign tick = run && (div_q >= psc);

  always_ff @(posedge clk) begin
    if (rst)       div_q <= '0;
    else if (!run) div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  assert_divider_restart_R1: assert property (@(posedge clk) disable iff (rst)
    !run |=> (div_q == '0));
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] per_d,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_d,
  input  logic             load,
  output logic [CNT_W-1:0] per_stage,
  output logic [CNT_W-1:0] cmp_act
);
  logic             mode_q;
  logic             mode_rise;
  logic [CNT_W-1:0] cmp_stage;

  assign mode_rise = mode && !mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= 1'b0;
      per_stage <= '0;
      cmp_stage <= '0;
      cmp_act   <= '0;
    end else begin
      mode_q <= mode;
      if (mode_rise) begin
        per_stage <= '0;
        cmp_stage <= '0;
        cmp_act   <= '0;
      end else begin
        if (per_wr) per_stage <= per_d;
        if (cmp_wr) cmp_stage <= cmp_d;
        if (load)   cmp_act   <= cmp_stage;
      end
    end
  end

  assert_mode_clear_R7: assert property (@(posedge clk) disable iff (rst)
    mode_rise |=> (per_stage == '0 && cmp_act == '0));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  pwm_chan_pkg::pwm_ctrl_t ctrl,
  input  logic             tick,
  input  logic [CNT_W-1:0] per_stage,
  input  logic [CNT_W-1:0] cmp_act,
  output logic             load,
  output logic             zero_hit,
  output logic [CNT_W-1:0] cnt,
  output logic             pwm_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic fresh;
  logic raw;

  assign load     = tick && (fresh || (cnt == '0 && ctrl.reload));
  assign zero_hit = tick && !load && (cnt == ONE);
  assign raw      = ctrl.run && (cnt > cmp_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      fresh <= 1'b1;
      pwm_o <= 1'b0;
    end else begin
      if (!ctrl.run) fresh <= 1'b1;
      else if (tick) fresh <= 1'b0;
      if (load)                    cnt <= per_stage;
      else if (tick && cnt != '0)  cnt <= cnt - ONE;
      pwm_o <= ctrl.oe & (raw ^ ctrl.inv);
    end
  end

  assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (rst)
    !ctrl.run |=> $stable(cnt));
  assert_start_load_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(per_stage)));
  assert_oneshot_halt_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !ctrl.reload && !fresh) |=> (cnt == '0));
  assert_idle_level_R6: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.run && ctrl.oe) |=> (pwm_o == $past(ctrl.inv)));
endmodule

// File: rtl/pwm_irq.sv
module pwm_irq (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic ien,
  output logic irq
);
  logic flag_q;
  logic flag_d;

  assign flag_d = set ? 1'b1 : (clr ? 1'b0 : flag_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq    <= flag_d & ien;
    end
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    set |=> flag_q);
endmodule

// File: rtl/pwm_down_channel.sv
module pwm_down_channel #(
  parameter int PSC_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PSC_W-1:0] prescale,
  input  logic             run_en,
  input  logic             mode_reload,
  input  logic             out_inv,
  input  logic             out_en,
  input  logic             irq_en,
  input  logic             period_wr,
  input  logic [CNT_W-1:0] period_data,
  input  logic             duty_wr,
  input  logic [CNT_W-1:0] duty_data,
  input  logic             flag_clr,
  output logic             pwm_out,
  output logic [CNT_W-1:0] count_val,
  output logic             irq
);
  import pwm_chan_pkg::*;

  pwm_ctrl_t        ctrl;
  logic             tick;
  logic             load;
  logic             zero_hit;
  logic [CNT_W-1:0] per_stage;
  logic [CNT_W-1:0] cmp_act;

  assign ctrl = '{run: run_en, reload: mode_reload, inv: out_inv, oe: out_en};

  pwm_prescaler #(.PSC_W(PSC_W)) u_div (
    .clk(clk), .rst(rst), .run(run_en), .psc(prescale), .tick(tick)
  );

  pwm_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk(clk), .rst(rst), .mode(mode_reload),
    .per_wr(period_wr), .per_d(period_data),
    .cmp_wr(duty_wr), .cmp_d(duty_data),
    .load(load), .per_stage(per_stage), .cmp_act(cmp_act)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .ctrl(ctrl), .tick(tick),
    .per_stage(per_stage), .cmp_act(cmp_act),
    .load(load), .zero_hit(zero_hit), .cnt(count_val), .pwm_o(pwm_out)
  );

  pwm_irq u_irq (
    .clk(clk), .rst(rst), .set(zero_hit), .clr(flag_clr),
    .ien(irq_en), .irq(irq)
  );
endmodule

// File: tb/sim_pwm_down_channel.sv
module sim_pwm_down_channel;
  localparam int PW = 8;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic [PW-1:0] prescale = '0;
  logic          run_en = 0, mode_reload = 0, out_inv = 0, out_en = 0, irq_en = 0;
  logic          period_wr = 0, duty_wr = 0, flag_clr = 0;
  logic [CW-1:0] period_data = '0, duty_data = '0;
  logic          pwm_out, irq;
  logic [CW-1:0] count_val;

  pwm_down_channel #(.PSC_W(PW), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .prescale(prescale), .run_en(run_en),
    .mode_reload(mode_reload), .out_inv(out_inv), .out_en(out_en),
    .irq_en(irq_en), .period_wr(period_wr), .period_data(period_data),
    .duty_wr(duty_wr), .duty_data(duty_data), .flag_clr(flag_clr),
    .pwm_out(pwm_out), .count_val(count_val), .irq(irq)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;
  string phase = "R9";

  // reference model built from the requirements
  logic [PW-1:0] m_pre;
  logic [CW-1:0] m_cnt, m_cmp, m_pst, m_cst;
  logic          m_fresh, m_flag, m_mq, m_pwm, m_irq;

  always @(posedge clk) begin
    logic tk, ld, rise, st, fl;
    if (rst) begin
      m_pre <= '0; m_cnt <= '0; m_cmp <= '0; m_pst <= '0; m_cst <= '0;
      m_fresh <= 1'b1; m_flag <= 1'b0; m_mq <= 1'b0; m_pwm <= 1'b0; m_irq <= 1'b0;
    end else begin
      tk   = run_en && (m_pre >= prescale);
      rise = mode_reload && !m_mq;
      ld   = tk && (m_fresh || (m_cnt == 0 && mode_reload));
      st   = tk && !ld && (m_cnt == 1);
      fl   = st ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
      m_pre   <= (!run_en || tk) ? '0 : m_pre + 1'b1;
      m_cnt   <= ld ? m_pst : ((tk && m_cnt != 0) ? m_cnt - 1'b1 : m_cnt);
      m_pst   <= rise ? '0 : (period_wr ? period_data : m_pst);
      m_cst   <= rise ? '0 : (duty_wr ? duty_data : m_cst);
      m_cmp   <= rise ? '0 : (ld ? m_cst : m_cmp);
      m_fresh <= !run_en ? 1'b1 : (tk ? 1'b0 : m_fresh);
      m_flag  <= fl;
      m_irq   <= fl & irq_en;
      m_mq    <= mode_reload;
      m_pwm   <= out_en & ((run_en && (m_cnt > m_cmp)) ^ out_inv);
    end
  end

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (phase %s) cycle %0d: actual=%0d expected=%0d", req, phase, cyc, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk("R2", count_val, m_cnt);
    chk("R6", CW'(pwm_out), CW'(m_pwm));
    chk("R8", CW'(irq), CW'(m_irq));
    period_wr = 0; duty_wr = 0; flag_clr = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
    end
  end

  logic [CW-1:0] snap;

  initial begin
    void'($urandom(32'h5eed_0042));
    @(negedge clk);
    repeat (3) step();
    rst = 0;
    step();
    // R9: reset state
    chk("R9", count_val, 0); chk("R9", CW'(pwm_out), 0); chk("R9", CW'(irq), 0);

    // R7 rise with reset values, then stage values (R4)
    phase = "R3";
    mode_reload = 1; step();
    period_wr = 1; period_data = 5; step();
    duty_wr = 1; duty_data = 2; step();
    out_en = 1; irq_en = 1; prescale = 0; run_en = 1;
    step();
    chk("R3", count_val, 5);
    repeat (5) step();
    chk("R8", count_val, 0); chk("R8", CW'(irq), 1);
    step();
    chk("R5", count_val, 5);

    // R4: mid-cycle write does not disturb running cycle
    phase = "R4";
    step(); snap = count_val;
    period_wr = 1; period_data = 3; step();
    chk("R4", count_val, snap - 1);
    for (int i = 0; i < 12 && count_val != 0; i++) step();
    step();
    chk("R4", count_val, 3);

    // R8: clear held continuously; set wins on the zero edge
    phase = "R8";
    step(); flag_clr = 1; step();
    chk("R8", CW'(irq), 0);
    for (int i = 0; i < 8 && count_val != 1; i++) begin flag_clr = 1; step(); end
    flag_clr = 1; step();
    chk("R8", count_val, 0); chk("R8", CW'(irq), 1);
    flag_clr = 1; step();
    chk("R8", CW'(irq), 0);

    // R5: one-shot halts at zero
    phase = "R5";
    mode_reload = 0;
    for (int i = 0; i < 10 && count_val != 0; i++) step();
    repeat (10) step();
    chk("R5", count_val, 0);

    // R2: hold when stopped; restart reloads
    run_en = 0; repeat (2) step();
    run_en = 1; step();
    chk("R3", count_val, 3);
    step(); snap = count_val;
    run_en = 0; repeat (5) step();
    chk("R2", count_val, snap);

    // R6: stopped output level follows inversion and gating
    phase = "R6";
    out_inv = 1; repeat (2) step();
    chk("R6", CW'(pwm_out), 1);
    out_inv = 0; repeat (2) step();
    chk("R6", CW'(pwm_out), 0);
    out_inv = 1; out_en = 0; repeat (2) step();
    chk("R6", CW'(pwm_out), 0);
    out_inv = 0; out_en = 1;

    // R1: divider spacing with prescale 3
    phase = "R1";
    mode_reload = 1; step();
    period_wr = 1; period_data = 7; step();
    duty_wr = 1; duty_data = 3; step();
    prescale = 3; run_en = 1;
    for (int i = 0; i < 8 && count_val != 7; i++) step();
    chk("R1", count_val, 7);
    repeat (3) step();
    chk("R1", count_val, 7);
    step();
    chk("R1", count_val, 6);

    // R7: mode rise beats a same-cycle write
    phase = "R7";
    run_en = 0; mode_reload = 0; step();
    mode_reload = 1; period_wr = 1; period_data = 9; step();
    prescale = 0; run_en = 1; repeat (6) step();
    chk("R7", count_val, 0);

    // constrained random mix
    phase = "R4";
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(15) == 0) begin period_wr = 1; period_data = CW'($urandom_range(20)); end
      if ($urandom_range(15) == 0) begin duty_wr = 1; duty_data = CW'($urandom_range(20)); end
      if ($urandom_range(7) == 0) flag_clr = 1;
      if ($urandom_range(99) == 0) run_en = ~run_en;
      if ($urandom_range(199) == 0) mode_reload = ~mode_reload;
      if ($urandom_range(99) == 0) out_inv = ~out_inv;
      if ($urandom_range(99) == 0) out_en = ~out_en;
      if ($urandom_range(49) == 0) irq_en = ~irq_en;
      if ($urandom_range(199) == 0) prescale = PW'($urandom_range(3));
      step();
    end
    summary();
  end
endmodule